// File: doc/BRIEF.md
# Serial Audio Sample-Pair Receiver

This block takes stereo PCM audio from a three-wire serial link and hands it on as parallel sample pairs. The link has a bit clock, a frame clock whose level marks the channel, and a data line. All three are sampled by the system master clock. The frame clock changes once per sample period. Each change ends the word in progress and starts a new one in the channel given by the new level. Data bits are two's complement, most significant bit first. Each bit is taken on a rising bit-clock edge.

Words are captured with a fixed left-justified framing: the first bit after a frame-clock change is the most significant bit. The word length is set at build time. A left word and the right word after it leave together as one aligned pair, marked by a one-cycle strobe, with both samples widened to 24 bits. A right word and the left word after it are never merged. A right word with no left partner is dropped, so left/right ordering keeps its one-period skew. A word cut short by an early frame-clock change is padded with zeros at the low end and flagged.

Top module: `audio_pair_rx`

## Requirements
- R1: While `rst` is high at a master-clock edge, all state is cleared. After that edge `pair_valid`, both samples and both truncation flags read 0, and no half-built pair survives the reset.
- R2: Data bits are taken on rising bit-clock edges, most significant bit first. Bits that arrive before the first frame-clock change after reset belong to no word.
- R3: Frame clock high means left and low means right. Each frame-clock change ends the current word and starts a new word in the channel of the new level.
- R4: When a right word ends and a left word is waiting, `pair_valid` is high for exactly one master-clock cycle. With two synchroniser stages this is the cycle after the third rising master-clock edge that follows the frame-clock change. The pulse carries that left word and that right word.
- R5: A right word that ends with no left word waiting is discarded. A right word is never paired with the left word that follows it.
- R6: Bits after the first WORD_LEN bits of a word have no effect on its value or its flag.
- R7: Each sample is the WORD_LEN-bit word sign-extended to 24 bits.
- R8: A word of 1 to WORD_LEN-1 bits is placed at the top of the WORD_LEN-bit field with zeros below it. Its flag (`left_trunc` or `right_trunc`) is 1. A full word has its flag at 0.
- R9: A word of zero bits produces no sample. A left word of zero bits also cancels any left word still waiting, so the right word after it is discarded.
- R10: Between pulses of `pair_valid`, both samples and both flags keep the values of the last pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Frame clock, high for left, low for right |
| sdata_in | input | 1 | Serial data, MSB first |
| pair_valid | output | 1 | One-cycle strobe marking a new sample pair |
| left_sample | output | 24 | Left sample, sign-extended |
| right_sample | output | 24 | Right sample, sign-extended |
| left_trunc | output | 1 | Left word was cut short |
| right_trunc | output | 1 | Right word was cut short |

## Verification
The bench builds the receiver with WORD_LEN set to 20 and two synchroniser stages. With a 20-bit word, one stream can carry words that are exactly full, longer than the word (24 bits), and shorter (12 and 5 bits). The 4-bit gap between 20 and 24 also makes the sign extension visible in the top bits of both samples. The reference model predicts the exact master-clock cycle of every pulse from the frame-clock change, so with two stages any added or missing register in the path is caught. Resets are applied after a lone left word and before the first frame change, which exercises the discard and cleanup paths.

// File: rtl/apr_pkg.sv
package apr_pkg;

    // Width of the parallel samples leaving the block.
    localparam int OUT_W = 24;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

    // One finished word handed from the deserialiser to the pairing stage.
    typedef struct packed {
        chan_e              chan;
        logic               empty;
        logic               trunc;
        logic [OUT_W-1:0]   data;
    } word_t;

    // One released stereo pair.
    typedef struct packed {
        logic [OUT_W-1:0]   left;
        logic [OUT_W-1:0]   right;
        logic               left_trunc;
        logic               right_trunc;
    } pair_t;

    // Sign-extend a word whose bits sit at the top of OUT_W: shift it
    // back down arithmetically by the unused low width.
    function automatic logic [OUT_W-1:0] top_to_signed(
        input logic [OUT_W-1:0] aligned,
        input int unsigned      low_pad
    );
        return OUT_W'($signed(aligned) >>> low_pad);
    endfunction

endpackage

// File: rtl/apr_sync.sv
module apr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/apr_deser.sv
module apr_deser
    import apr_pkg::*;
#(
    parameter int WORD_LEN = 24
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_stb,
    input  logic  bit_val,
    input  logic  frame_stb,
    input  logic  frame_lvl,
    output logic  word_done,
    output word_t word
);

    localparam int CW      = $clog2(WORD_LEN + 1);
    localparam int LOW_PAD = OUT_W - WORD_LEN;

    logic                active;
    chan_e               chan;
    logic [WORD_LEN-1:0] shreg;
    logic [CW-1:0]       cnt;
    logic [5:0]          up_shift;
    logic [OUT_W-1:0]    aligned;

    // A frame edge closes the word in progress and opens the next one.
    // Bits arriving before the first frame edge are dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            chan   <= CH_RIGHT;
            shreg  <= '0;
            cnt    <= '0;
        end else if (frame_stb) begin
            active <= 1'b1;
            chan   <= chan_e'(frame_lvl);
            shreg  <= '0;
            cnt    <= '0;
        end else if (bit_stb && active && (cnt < CW'(WORD_LEN))) begin
            shreg  <= {shreg[WORD_LEN-2:0], bit_val};
            cnt    <= cnt + 1'b1;
        end
    end

    // Move the received bits to the top of the output width, leaving zeros
    // below for a short word, then sign-extend down to WORD_LEN.
    always_comb begin
        up_shift = 6'(OUT_W) - 6'(cnt);
        aligned  = OUT_W'(shreg) << up_shift;
    end

    assign word_done  = frame_stb && active;
    assign word.chan  = chan;
    assign word.empty = (cnt == '0);
    assign word.trunc = (cnt < CW'(WORD_LEN));
    assign word.data  = top_to_signed(aligned, LOW_PAD);

endmodule

// File: rtl/apr_pair.sv
module apr_pair
    import apr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  word_done,
    input  word_t word,
    output logic  pair_valid,
    output pair_t pair
);

    logic             pend;
    logic [OUT_W-1:0] pend_data;
    logic             pend_trunc;

    // A left word waits for the right word after it. A right word with no
    // partner is dropped, so right/left order is never merged.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            pend_data  <= '0;
            pend_trunc <= 1'b0;
            pair_valid <= 1'b0;
            pair       <= '0;
        end else begin
            pair_valid <= 1'b0;
            if (word_done) begin
                if (word.chan == CH_LEFT) begin
                    pend       <= !word.empty;
                    pend_data  <= word.data;
                    pend_trunc <= word.trunc;
                end else begin
                    pend <= 1'b0;
                    if (pend && !word.empty) begin
                        pair_valid       <= 1'b1;
                        pair.left        <= pend_data;
                        pair.left_trunc  <= pend_trunc;
                        pair.right       <= word.data;
                        pair.right_trunc <= word.trunc;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/audio_pair_rx.sv
module audio_pair_rx
    import apr_pkg::*;
#(
    parameter int WORD_LEN    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_in,
    input  logic             fclk_in,
    input  logic             sdata_in,
    output logic             pair_valid,
    output logic [OUT_W-1:0] left_sample,
    output logic [OUT_W-1:0] right_sample,
    output logic             left_trunc,
    output logic             right_trunc
);

    logic [2:0] raw_in;
    logic [2:0] sync_q;
    logic       bclk_s, fclk_s, sdata_s;
    logic       bclk_d, fclk_d;
    logic       bit_stb, frame_stb;
    logic       word_done;
    word_t      word;
    pair_t      pair;

    // All three wires pass through the same synchroniser depth, so their
    // relative timing is kept.
    assign raw_in = {sdata_in, fclk_in, bclk_in};

    apr_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    assign bclk_s  = sync_q[0];
    assign fclk_s  = sync_q[1];
    assign sdata_s = sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d <= 1'b0;
            fclk_d <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            fclk_d <= fclk_s;
        end
    end

    assign bit_stb   = bclk_s && !bclk_d;
    assign frame_stb = fclk_s ^ fclk_d;

    apr_deser #(
        .WORD_LEN (WORD_LEN)
    ) deser_i (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_val   (sdata_s),
        .frame_stb (frame_stb),
        .frame_lvl (fclk_s),
        .word_done (word_done),
        .word      (word)
    );

    apr_pair pair_i (
        .clk        (clk),
        .rst        (rst),
        .word_done  (word_done),
        .word       (word),
        .pair_valid (pair_valid),
        .pair       (pair)
    );

    assign left_sample  = pair.left;
    assign right_sample = pair.right;
    assign left_trunc   = pair.left_trunc;
    assign right_trunc  = pair.right_trunc;

endmodule

// File: rtl/apr_checker.sv
module apr_checker
    import apr_pkg::*;
#(
    parameter int WORD_LEN = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             pair_valid,
    input logic [OUT_W-1:0] left_sample,
    input logic [OUT_W-1:0] right_sample,
    input logic             left_trunc,
    input logic             right_trunc,
    input logic             frame_stb,
    input logic             fclk_s
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!pair_valid && left_sample == '0 && right_sample == '0
                 && !left_trunc && !right_trunc));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    // A pair follows the frame edge that ends a right word (new level is left).
    assert_after_left_edge_R3: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> ($past(frame_stb) && $past(fclk_s)));

    assert_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> (((&left_sample[OUT_W-1:WORD_LEN-1]) || !(|left_sample[OUT_W-1:WORD_LEN-1]))
                     && ((&right_sample[OUT_W-1:WORD_LEN-1]) || !(|right_sample[OUT_W-1:WORD_LEN-1]))));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(left_sample) && $stable(right_sample)
                         && $stable(left_trunc) && $stable(right_trunc)));

endmodule

bind audio_pair_rx apr_checker #(
    .WORD_LEN (WORD_LEN)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .pair_valid   (pair_valid),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .left_trunc   (left_trunc),
    .right_trunc  (right_trunc),
    .frame_stb    (frame_stb),
    .fclk_s       (fclk_s)
);

// File: tb/audio_pair_rx_tb_top.sv
`timescale 1ns/1ps
module audio_pair_rx_tb_top;

    localparam int W = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
    logic        pair_valid;
    logic [23:0] left_sample, right_sample;
    logic        left_trunc, right_trunc;

    always #2 clk = ~clk;

    audio_pair_rx #(.WORD_LEN(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .bclk_in(bclk), .fclk_in(fclk), .sdata_in(sdata),
        .pair_valid(pair_valid), .left_sample(left_sample), .right_sample(right_sample),
        .left_trunc(left_trunc), .right_trunc(right_trunc)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    checks = 0, errors = 0;
    string req = "R1";
    bit    done = 0;

    typedef struct {
        int          at;
        logic [23:0] l;
        logic [23:0] r;
        logic        lt;
        logic        rt;
    } exp_t;
    exp_t expq[$];

    // Behavioural reference state.
    bit          m_active, m_left, m_pend, m_pend_tr;
    logic [23:0] m_pend_val;
    bit          m_bits[$];
    logic [23:0] last_l = '0, last_r = '0;
    logic        last_lt = 1'b0, last_rt = 1'b0;

    function automatic logic [23:0] fin(input bit b[$]);
        int v = 0;
        for (int i = 0; i < W; i++) v = (v << 1) | ((i < b.size()) ? int'(b[i]) : 0);
        if (v >= (1 << (W-1))) v -= (1 << W);
        return 24'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [49:0] got, input logic [49:0] want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, got, want);
        end
    endtask

    // Compared on every clock against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (expq.size() > 0 && expq[0].at == cyc) begin
                chk(pair_valid == 1'b1, "R4", {49'd0, pair_valid}, 50'd1);
                chk({left_sample, right_sample, left_trunc, right_trunc} ==
                    {expq[0].l, expq[0].r, expq[0].lt, expq[0].rt}, req,
                    {left_sample, right_sample, left_trunc, right_trunc},
                    {expq[0].l, expq[0].r, expq[0].lt, expq[0].rt});
                last_l = expq[0].l; last_r = expq[0].r;
                last_lt = expq[0].lt; last_rt = expq[0].rt;
                void'(expq.pop_front());
            end else begin
                chk(pair_valid == 1'b0, req, {49'd0, pair_valid}, 50'd0);
                chk({left_sample, right_sample, left_trunc, right_trunc} ==
                    {last_l, last_r, last_lt, last_rt}, "R10",
                    {left_sample, right_sample, left_trunc, right_trunc},
                    {last_l, last_r, last_lt, last_rt});
            end
        end
    end

    task automatic frame(input bit lvl);
        int          n;
        bit          tr;
        logic [23:0] v;
        @(negedge clk);
        if (m_active) begin
            n  = m_bits.size();
            tr = (n < W);
            v  = fin(m_bits);
            if (m_left) begin
                m_pend = (n > 0); m_pend_val = v; m_pend_tr = tr;
            end else begin
                if (m_pend && n > 0) expq.push_back('{cyc + 3, m_pend_val, v, m_pend_tr, tr});
                m_pend = 0;
            end
        end
        m_active = 1; m_left = lvl; m_bits.delete();
        fclk = lvl;
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); sdata = b;
        if (m_active) m_bits.push_back(b);
        @(negedge clk); bclk = 1'b1;
        @(negedge clk); @(negedge clk); bclk = 1'b0;
    endtask

    task automatic send_word(input int n, input logic [31:0] pat);
        for (int i = 0; i < n; i++) send_bit(pat[31-i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fclk = 1'b0; bclk = 1'b0; sdata = 1'b0;
        m_active = 0; m_pend = 0; m_bits.delete(); expq.delete();
        last_l = '0; last_r = '0; last_lt = 1'b0; last_rt = 1'b0;
        repeat (3) @(negedge clk);
        chk({pair_valid, left_sample, right_sample, left_trunc, right_trunc} == '0, "R1",
            {1'b0, left_sample, right_sample, left_trunc}, 50'd0);
        rst = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
        chk(expq.size() == 0, "R4", 50'(expq.size()), 50'd0);
    endtask

    initial begin
        do_reset();

        req = "R2";                      // stray bits before any frame edge
        send_word(5, 32'hF800_0000);
        req = "R3";
        frame(1); send_word(20, 32'h5A5A_5000);
        frame(0); send_word(20, 32'hC3C3_C000);
        req = "R6";
        frame(1); send_word(24, 32'h1234_56F0);
        frame(0); send_word(20, 32'h8000_1000);
        req = "R8";
        frame(1); send_word(12, 32'hFFF0_0000);
        frame(0); send_word(20, 32'h7FFF_F000);
        req = "R7";
        frame(1); send_word(20, 32'hABCD_E000);
        frame(0); send_word(5,  32'h5800_0000);
        req = "R9";
        frame(1); send_word(20, 32'h1111_1000);
        frame(0);                        // zero-bit right word
        frame(1);                        // zero-bit left word
        frame(0); send_word(20, 32'h2222_2000);
        frame(1); send_word(20, 32'h0F0F_0000);
        frame(0); send_word(20, 32'hF0F0_F000);
        frame(1);
        settle();

        do_reset();
        req = "R5";                      // stream opens on a right word
        frame(1);
        frame(0); send_word(20, 32'h3333_3000);
        frame(1); send_word(20, 32'h4444_4000);
        frame(0); send_word(20, 32'h5555_5000);
        frame(1);
        settle();

        req = "R1";                      // reset drops a waiting left word
        send_word(20, 32'h6666_6000);
        do_reset();
        frame(1);
        frame(0); send_word(20, 32'h7777_7000);
        frame(1);
        settle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule